// File: doc/BRIEF.md
# Nibble-Stride Buffer Address Generator

This block produces the buffer address for one streaming port on a shared memory whose sixteen banks come into reach in turn. It does not step the low four address bits by one. It adds a programmable stride to them, modulo 16, so that each access falls on the bank slot that a short code loop reaches next. The upper address bits select a 16-word page. They stay fixed until the low nibble comes back to the value it had when the base was loaded. On that step the page advances by one and a one-cycle carry pulse is raised.

The port is set up with a load strobe that captures a base address and a stride. The start nibble that the return comparison uses is the low nibble of that base. Every step strobe after that moves the address by one stride. With an odd stride a page is filled completely, in a scrambled order, before the page advances. A reader that loads the same base and stride steps through the same addresses in the same order. Each instance holds its own stride, so ports that share the memory do not affect one another.

Top module: `nib_stride_agen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and carry_o is 0. The stored stride resets to 1 and the start nibble to 0.
- R2: When load_i is high at a clock edge, the next cycle shows addr_o equal to base_i and carry_o at 0. stride_i and base_i[3:0] are captured as the stride and the start nibble.
- R3: When step_i is high and load_i low at an edge, addr_o[3:0] becomes (addr_o[3:0] + stride) mod 16. If the new nibble differs from the start nibble, addr_o[19:4] is held.
- R4: When a step makes the new nibble equal to the start nibble, addr_o[19:4] increments by one in that same update, and carry_o is high for exactly that one following cycle.
- R5: With stride 1 and a base nibble of 0, the address counts up linearly. After 16 steps it reaches the start of the next page.
- R6: With any odd stride, the 16 addresses before the first carry cover all 16 nibble values once each. From start nibble 0xA with stride 7 the order is 1,8,F,6,D,4,B,2,9,0,7,E,5,C,3,A.
- R7: With an even stride the nibble still wraps modulo 16, and the carry fires after fewer than 16 steps: after 16/gcd(stride,16) steps, or on every step for stride 0.
- R8: A carry out of page 0xFFFF wraps the page to 0x0000.
- R9: With step_i and load_i both low, addr_o holds its value and carry_o is 0.
- R10: If load_i and step_i are high at the same edge, the load wins and no step is applied.
- R11: Two instances loaded with the same base and stride produce identical address sequences. An instance with a different stride does not disturb the other one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture base_i and stride_i |
| base_i | input | 20 | Base address; its low nibble becomes the start nibble |
| stride_i | input | 4 | Low-nibble increment |
| step_i | input | 1 | Advance the address by one stride |
| addr_o | output | 20 | Current buffer address |
| carry_o | output | 1 | One-cycle pulse when the page advances |

## Verification
Any wrong internal state shows at the ports within one step. A corrupted stride gives the wrong next nibble on the first step. A stale or wrong start nibble moves the carry to the wrong step and the page increment with it. A dropped page increment shows on the carry step. The bench follows full page laps with odd, even, zero and all-ones strides, and runs a wrap at the top page. Each carry's position and the final address are checked against values worked out from the requirements.

// File: rtl/nsa_pkg.sv
package nsa_pkg;
  localparam int unsigned NSA_ADDR_W = 20;
  localparam int unsigned NSA_NIB_W  = 4;
endpackage

// File: rtl/nsa_nib_step.sv
module nsa_nib_step #(
  parameter int unsigned NIB_W = nsa_pkg::NSA_NIB_W
) (
  input  logic [NIB_W-1:0] nib_i,
  input  logic [NIB_W-1:0] stride_i,
  input  logic [NIB_W-1:0] start_i,
  output logic [NIB_W-1:0] nib_o,
  output logic             wrap_o
);
  always_comb begin
    nib_o  = nib_i + stride_i;  // natural modulo 2**NIB_W
    wrap_o = (nib_o == start_i);
  end
endmodule

// File: rtl/nsa_page_ctr.sv
module nsa_page_ctr #(
  parameter int unsigned PAGE_W = nsa_pkg::NSA_ADDR_W - nsa_pkg::NSA_NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] base_i,
  input  logic              inc_i,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_o <= '0;
    else if (load_i) page_o <= base_i;
    else if (inc_i)  page_o <= page_o + PAGE_W'(1);  // top page wraps to 0
  end
endmodule

// File: rtl/nib_stride_agen.sv
module nib_stride_agen #(
  parameter int unsigned ADDR_W = nsa_pkg::NSA_ADDR_W,
  parameter int unsigned NIB_W  = nsa_pkg::NSA_NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [NIB_W-1:0]  stride_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              carry_o
);
  localparam int unsigned PAGE_W = ADDR_W - NIB_W;

  logic [NIB_W-1:0]  nib_q, start_q, stride_q, nib_nxt;
  logic [PAGE_W-1:0] page_q;
  logic              wrap, adv;

  assign adv = step_i & ~load_i;

  nsa_nib_step #(.NIB_W(NIB_W)) u_nib_step (
    .nib_i   (nib_q),
    .stride_i(stride_q),
    .start_i (start_q),
    .nib_o   (nib_nxt),
    .wrap_o  (wrap)
  );

  nsa_page_ctr #(.PAGE_W(PAGE_W)) u_page_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .base_i(base_i[ADDR_W-1:NIB_W]),
    .inc_i (adv & wrap),
    .page_o(page_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nib_q    <= '0;
      start_q  <= '0;
      stride_q <= NIB_W'(1);
      carry_o  <= 1'b0;
    end else if (load_i) begin
      nib_q    <= base_i[NIB_W-1:0];
      start_q  <= base_i[NIB_W-1:0];
      stride_q <= stride_i;
      carry_o  <= 1'b0;
    end else begin
      if (step_i) nib_q <= nib_nxt;
      carry_o <= step_i & wrap;
    end
  end

  assign addr_o = {page_q, nib_q};
endmodule

// File: rtl/nib_stride_agen_chk.sv
module nib_stride_agen_chk #(
  parameter int unsigned ADDR_W = nsa_pkg::NSA_ADDR_W,
  parameter int unsigned NIB_W  = nsa_pkg::NSA_NIB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [ADDR_W-1:0] base_i,
  input logic              step_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              carry_o,
  input logic [NIB_W-1:0]  stride_q,
  input logic [NIB_W-1:0]  start_q
);
  localparam int unsigned PAGE_W = ADDR_W - NIB_W;

  // R2
  load_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(base_i)) && !carry_o);

  // R3
  step_nib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=>
      addr_o[NIB_W-1:0] == NIB_W'($past(addr_o[NIB_W-1:0]) + $past(stride_q)));

  // R3
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> carry_o || $stable(addr_o[ADDR_W-1:NIB_W]));

  // R4
  carry_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (addr_o[NIB_W-1:0] == start_q) &&
      (addr_o[ADDR_W-1:NIB_W] == PAGE_W'($past(addr_o[ADDR_W-1:NIB_W]) + PAGE_W'(1))));

  // R4
  carry_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> $past(step_i) && !$past(load_i));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_o) && !carry_o);
endmodule

bind nib_stride_agen nib_stride_agen_chk #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .base_i  (base_i),
  .step_i  (step_i),
  .addr_o  (addr_o),
  .carry_o (carry_o),
  .stride_q(stride_q),
  .start_q (start_q)
);

// File: tb/test_nib_stride_agen.sv
module test_nib_stride_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0, step = 1'b0;
  logic [19:0] base = '0;
  logic [3:0]  stride = '0;
  logic [19:0] addr;
  logic        carry;
  logic        r_load = 1'b0, r_step = 1'b0;
  logic [19:0] r_base = '0;
  logic [3:0]  r_stride = '0;
  logic [19:0] r_addr;
  logic        r_carry;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nib_stride_agen i_nib_stride_agen (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .base_i(base),
    .stride_i(stride), .step_i(step), .addr_o(addr), .carry_o(carry));

  nib_stride_agen i_reader (
    .clk_i(clk), .rst_ni(rst_n), .load_i(r_load), .base_i(r_base),
    .stride_i(r_stride), .step_i(r_step), .addr_o(r_addr), .carry_o(r_carry));

  typedef struct packed {
    logic [19:0] base;
    logic [3:0]  stride;
    logic [7:0]  steps;
    logic [19:0] exp_addr;
    logic [7:0]  exp_carries;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{20'h0000A, 4'd7,  8'd16, 20'h0001A, 8'd1},  // R6
    '{20'h12340, 4'd1,  8'd15, 20'h1234F, 8'd0},  // R5
    '{20'h12340, 4'd1,  8'd16, 20'h12350, 8'd1},  // R5
    '{20'hFFFF3, 4'd5,  8'd16, 20'h00003, 8'd1},  // R8
    '{20'h00005, 4'd4,  8'd4,  20'h00015, 8'd1},  // R7
    '{20'h00005, 4'd4,  8'd3,  20'h00001, 8'd0},  // R7
    '{20'h0ABC7, 4'd0,  8'd3,  20'h0ABF7, 8'd3},  // R7
    '{20'h00003, 4'd3,  8'd40, 20'h0002B, 8'd2},  // R3
    '{20'h40008, 4'd15, 8'd17, 20'h40017, 8'd1}   // R4
  };

  localparam logic [3:0] SEQ_A7 [16] = '{4'h1, 4'h8, 4'hF, 4'h6, 4'hD, 4'h4, 4'hB, 4'h2,
                                         4'h9, 4'h0, 4'h7, 4'hE, 4'h5, 4'hC, 4'h3, 4'hA};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [19:0] b, input logic [3:0] s);
    @(negedge clk);
    load = 1'b1; base = b; stride = s;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_step(output int carried);
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    carried = int'(carry);
  endtask

  initial begin
    int c, ncar;
    logic [15:0] seen;
    logic [19:0] hold;
    repeat (3) @(negedge clk);
    chk(addr == 20'h0 && carry == 1'b0, "R1 reset state", {11'b0, carry, addr}, 32'h0);
    rst_n = 1'b1;
    // R1: reset stride is 1
    do_step(c);
    chk(addr == 20'h00001, "R1 reset stride", addr, 20'h00001);

    for (int v = 0; v < 9; v++) begin
      do_load(VECS[v].base, VECS[v].stride);
      chk(addr == VECS[v].base && !carry, "R2 load", addr, VECS[v].base);
      ncar = 0;
      for (int k = 0; k < int'(VECS[v].steps); k++) begin
        do_step(c);
        ncar += c;
      end
      chk(addr == VECS[v].exp_addr, $sformatf("R3/R4 vector %0d addr", v), addr, VECS[v].exp_addr);
      chk(ncar == int'(VECS[v].exp_carries), $sformatf("R4 vector %0d carries", v), ncar, VECS[v].exp_carries);
    end

    // R6: exact order and full coverage from 0xA stride 7
    do_load(20'h5550A, 4'd7);
    seen = '0;
    for (int k = 0; k < 16; k++) begin
      do_step(c);
      seen[addr[3:0]] = 1'b1;
      chk(addr[3:0] == SEQ_A7[k], $sformatf("R6 order step %0d", k), addr[3:0], SEQ_A7[k]);
      chk(c == (k == 15 ? 1 : 0), $sformatf("R4 carry position step %0d", k), c, (k == 15 ? 1 : 0));
    end
    chk(seen == 16'hFFFF, "R6 coverage", seen, 16'hFFFF);
    chk(addr == 20'h5551A, "R4 page advance", addr, 20'h5551A);
    // R4: carry lasts one cycle
    @(negedge clk);
    chk(!carry, "R4 single-cycle carry", carry, 0);
    do_step(c);
    chk(addr == 20'h55511, "R6 next lap wraps to 1", addr, 20'h55511);

    // R9: idle holds
    hold = addr;
    repeat (5) @(negedge clk);
    chk(addr == hold && !carry, "R9 idle hold", addr, hold);

    // R2: load clears a pending carry
    do_load(20'h0000F, 4'd0);
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0; load = 1'b1; base = 20'h33330; stride = 4'd1;
    chk(carry == 1'b1, "R7 zero stride carries", carry, 1);
    @(negedge clk);
    load = 1'b0;
    chk(!carry && addr == 20'h33330, "R2 load clears carry", {11'b0, carry, addr}, 32'h33330);

    // R10: load wins over step
    @(negedge clk);
    load = 1'b1; step = 1'b1; base = 20'h77774; stride = 4'd3;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    chk(addr == 20'h77774 && !carry, "R10 load priority", addr, 20'h77774);

    // R11: reader matches writer; different stride elsewhere does not disturb
    do_load(20'h2000C, 4'd9);
    @(negedge clk);
    r_load = 1'b1; r_base = 20'h2000C; r_stride = 4'd9;
    @(negedge clk);
    r_load = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      step = 1'b1; r_step = 1'b1;
      @(negedge clk);
      step = 1'b0; r_step = 1'b0;
      chk(addr == r_addr && carry == r_carry, $sformatf("R11 reader step %0d", k), r_addr, addr);
    end
    @(negedge clk);
    r_load = 1'b1; r_base = 20'h00000; r_stride = 4'd3;
    @(negedge clk);
    r_load = 1'b0; r_step = 1'b1;
    do_step(c);
    r_step = 1'b0;
    // writer: 0x2000C + 21 steps of 9 -> nib (12+189)%16 = 9, one carry -> 0x2001 page
    chk(addr == 20'h20019, "R11 independent stride", addr, 20'h20019);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule